// File: doc/BRIEF.md
# PCI Single-Word Memory Read Target

This block is the target end of a 32-bit PCI bus interface and serves memory reads that carry exactly one data phase. It watches the shared bus for the start of a cycle and captures the address and command from that first clock. It compares the address with up to six base address windows that software sets up. If one window matches, it claims the cycle and turns on its AD drivers at once, so the bus does not float while the data is fetched. It then hands the command, the address and the matching window to a local device.

The local device delivers one word through a two-signal handshake. The device raises a ready indication and the block raises an acknowledge. The transfer is counted in the first cycle in which the acknowledge is active and ready was already seen at the previous edge. The word is registered, put on AD with TRDY#, and covered by even parity one clock later. When the master's IRDY# and the block's TRDY# are both seen low, the block drives its control lines high for one cycle and then releases them. Addresses that match no window, and commands other than a memory read, are left alone.

The bus is modelled with separate input, output and output-enable signals. The pad ring combines them into the tri-state lines.

Top module: `pci_rd_target`

## Requirements
- R1: After reset, `ctl_oe`, `ad_oe`, `par_oe` and `loc_busy` are 0. `devsel_n_out`, `trdy_n_out`, `stop_n_out`, `loc_frame_n`, `loc_ack_n` and `loc_xfr_n` are 1, and `loc_hit` is all zeros.
- R2: The block claims a cycle only when three conditions hold: the command on C/BE# in the address-phase clock (the first clock with `frame_n` low while idle) is memory read, code 4'b0110; the window k is enabled (`bar_en[k]`=1); and the address satisfies (addr & mask_k) == (base_k & mask_k). If several windows match, the lowest index wins.
- R3: The address-phase clock is cycle 0. Cycle 1 is a turn-around cycle with `ad_oe`=0 and `ctl_oe`=0. In cycle 2 a hit drives `devsel_n_out` low, with `ctl_oe`=1 and `ad_oe`=1.
- R4: From cycle 2 until the block returns to idle, `loc_hit` has exactly bit k set for the winning window k and `loc_busy` is 1. In every other cycle `loc_hit` is zero and `loc_busy` is 0.
- R5: `loc_frame_n` is low for cycle 2 only. Throughout the claim, `loc_cmd` shows the captured command and `loc_addr` the captured address.
- R6: `loc_ack_n` is low from cycle 2 until the transfer cycle, that cycle included, and high afterwards.
- R7: `loc_xfr_n` is low for exactly one cycle: the first cycle that has `loc_ack_n` low and `loc_rdy_n` sampled low at the edge that began it. A ready raised before the claim therefore transfers in cycle 2.
- R8: `loc_data` is registered at the edge that ends the transfer cycle. In the next cycle AD carries that word and `trdy_n_out` is low.
- R9: `par_out` is even parity over the AD value driven and the `cbe_n` input of the previous cycle: the XOR of all 36 bits. `par_oe` is 1 in each cycle that follows a cycle with `ad_oe`=1.
- R10: Once `trdy_n_out` and `irdy_n` are both low at an edge, the next cycle drives `devsel_n_out` and `trdy_n_out` high with `ctl_oe`=1 and `ad_oe`=0. The cycle after that has `ctl_oe`=0 and the block is idle.
- R11: On a miss, `ctl_oe` stays 0, so DEVSEL#, TRDY# and STOP# are never driven. No local strobe is raised, and the block becomes idle after an edge that sees `frame_n` and `irdy_n` both high.
- R12: `stop_n_out` is never driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | FRAME# from the master |
| irdy_n | input | 1 | IRDY# from the master |
| cbe_n | input | 4 | C/BE# lines |
| ad_in | input | 32 | AD lines as received |
| ad_out | output | 32 | AD value driven by the target |
| ad_oe | output | 1 | Drive enable for AD |
| par_out | output | 1 | PAR value |
| par_oe | output | 1 | Drive enable for PAR |
| devsel_n_out | output | 1 | DEVSEL# value |
| trdy_n_out | output | 1 | TRDY# value |
| stop_n_out | output | 1 | STOP# value |
| ctl_oe | output | 1 | Drive enable for DEVSEL#, TRDY#, STOP# |
| bar_base | input | NBAR*32 | Window base addresses, window k at bits [32k+31:32k] |
| bar_mask | input | NBAR*32 | Address bits compared for each window |
| bar_en | input | NBAR | Window enable bits |
| loc_frame_n | output | 1 | One-cycle local strobe announcing a claimed read |
| loc_cmd | output | 4 | Captured command |
| loc_addr | output | 32 | Captured address |
| loc_hit | output | NBAR | One-hot winning window |
| loc_busy | output | 1 | Bus side occupied with a transaction |
| loc_rdy_n | input | 1 | Local device has data ready |
| loc_ack_n | output | 1 | Block ready to take local data |
| loc_xfr_n | output | 1 | Local transfer cycle marker |
| loc_data | input | 32 | Read data from the local device |

## Verification
The bench runs a read against every window with the local ready delayed by zero to three cycles. The zero-delay case raises ready before the claim. A design that transfers on ready alone would pulse the transfer strobe too early or twice; a design that skips the early-ready case would never fire it. Disabled windows, non-read commands, unmapped addresses and two overlapping windows are all tried. Wrong decoding, or a missing lowest-index priority, would show up as a claim on a miss or as the wrong hit bit. Parity and the turn-off cycle are checked at fixed offsets after the transfer, so one cycle of slip in the data register or the completion step is reported.

// File: rtl/pci_rd_pkg.sv
package pci_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DECODE  = 3'd1,
    ST_CLAIM   = 3'd2,
    ST_WAITX   = 3'd3,
    ST_DATA    = 3'd4,
    ST_TURNOFF = 3'd5,
    ST_NOHIT   = 3'd6
  } rd_state_t;

  localparam logic [3:0] CMD_MEM_READ = 4'b0110;

endpackage

// File: rtl/pci_bar_decode.sv
module pci_bar_decode #(
  parameter int NBAR = 6,
  parameter int AW   = 32
) (
  input  logic [AW-1:0]      addr,
  input  logic [3:0]         cmd,
  input  logic [NBAR*AW-1:0] bar_base,
  input  logic [NBAR*AW-1:0] bar_mask,
  input  logic [NBAR-1:0]    bar_en,
  output logic [NBAR-1:0]    hit_vec,
  output logic               any_hit
);
  import pci_rd_pkg::*;

  logic [NBAR-1:0] raw;
  logic            is_read;

  assign is_read = (cmd == CMD_MEM_READ);

  for (genvar k = 0; k < NBAR; k++) begin : g_win
    logic [AW-1:0] base_k;
    logic [AW-1:0] mask_k;
    assign base_k = bar_base[k*AW +: AW];
    assign mask_k = bar_mask[k*AW +: AW];
    assign raw[k] = bar_en[k] & is_read & ((addr & mask_k) == (base_k & mask_k));
  end

  // lowest set bit wins
  assign hit_vec = raw & (~raw + NBAR'(1));
  assign any_hit = |raw;

endmodule

// File: rtl/pci_loc_handshake.sv
module pci_loc_handshake #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loc_rdy_n,
  input  logic          ack_on,
  input  logic [DW-1:0] loc_data,
  output logic          xfr,
  output logic [DW-1:0] data_q
);

  logic rdy_q, rdy_d;
  logic [DW-1:0] data_d;

  always_comb begin
    rdy_d  = ~loc_rdy_n;
    data_d = data_q;
    if (xfr) data_d = loc_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      data_q <= '0;
    end else begin
      rdy_q  <= rdy_d;
      data_q <= data_d;
    end
  end

  // ready seen at the previous edge and acknowledge active now
  assign xfr = rdy_q & ack_on;

  AST_XFR_PRIOR_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    xfr |-> $past(loc_rdy_n) == 1'b0); // R7

endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ad,
  input  logic [CW-1:0] cbe_n,
  input  logic          oe,
  output logic          par,
  output logic          par_oe
);

  logic par_d, oe_d;

  always_comb begin
    par_d = par;
    oe_d  = oe;
    if (oe) par_d = ^{ad, cbe_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par    <= 1'b0;
      par_oe <= 1'b0;
    end else begin
      par    <= par_d;
      par_oe <= oe_d;
    end
  end

endmodule

// File: rtl/pci_rd_target.sv
module pci_rd_target #(
  parameter int NBAR = 6,
  parameter int AW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_n,
  input  logic               irdy_n,
  input  logic [3:0]         cbe_n,
  input  logic [AW-1:0]      ad_in,
  output logic [AW-1:0]      ad_out,
  output logic               ad_oe,
  output logic               par_out,
  output logic               par_oe,
  output logic               devsel_n_out,
  output logic               trdy_n_out,
  output logic               stop_n_out,
  output logic               ctl_oe,
  input  logic [NBAR*AW-1:0] bar_base,
  input  logic [NBAR*AW-1:0] bar_mask,
  input  logic [NBAR-1:0]    bar_en,
  output logic               loc_frame_n,
  output logic [3:0]         loc_cmd,
  output logic [AW-1:0]      loc_addr,
  output logic [NBAR-1:0]    loc_hit,
  output logic               loc_busy,
  input  logic               loc_rdy_n,
  output logic               loc_ack_n,
  output logic               loc_xfr_n,
  input  logic [AW-1:0]      loc_data
);
  import pci_rd_pkg::*;

  rd_state_t       state_q, state_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [3:0]      cmd_q, cmd_d;
  logic [NBAR-1:0] hit_q, hit_d;
  logic [NBAR-1:0] dec_hit;
  logic            dec_any;
  logic            xfr, ack_on;
  logic [AW-1:0]   rd_word;

  pci_bar_decode #(.NBAR(NBAR), .AW(AW)) u_dec (
    .addr    (addr_q),
    .cmd     (cmd_q),
    .bar_base(bar_base),
    .bar_mask(bar_mask),
    .bar_en  (bar_en),
    .hit_vec (dec_hit),
    .any_hit (dec_any)
  );

  pci_loc_handshake #(.DW(AW)) u_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .loc_rdy_n(loc_rdy_n),
    .ack_on   (ack_on),
    .loc_data (loc_data),
    .xfr      (xfr),
    .data_q   (rd_word)
  );

  pci_par_gen #(.DW(AW), .CW(4)) u_par (
    .clk   (clk),
    .rst_n (rst_n),
    .ad    (ad_out),
    .cbe_n (cbe_n),
    .oe    (ad_oe),
    .par   (par_out),
    .par_oe(par_oe)
  );

  // next state
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    cmd_d   = cmd_q;
    hit_d   = hit_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!frame_n) begin
          addr_d  = ad_in;
          cmd_d   = cbe_n;
          state_d = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (dec_any) begin
          hit_d   = dec_hit;
          state_d = ST_CLAIM;
        end else begin
          state_d = ST_NOHIT;
        end
      end
      ST_CLAIM, ST_WAITX: begin
        state_d = xfr ? ST_DATA : ST_WAITX;
      end
      ST_DATA: begin
        if (!irdy_n) state_d = ST_TURNOFF;
      end
      ST_TURNOFF: begin
        state_d = ST_IDLE;
      end
      ST_NOHIT: begin
        if (frame_n && irdy_n) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cmd_q   <= '0;
      hit_q   <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      cmd_q   <= cmd_d;
      hit_q   <= hit_d;
    end
  end

  // outputs decoded from the state register
  logic claimed;
  assign claimed = (state_q == ST_CLAIM) || (state_q == ST_WAITX) || (state_q == ST_DATA);

  assign ack_on       = (state_q == ST_CLAIM) || (state_q == ST_WAITX);
  assign ad_oe        = claimed;
  assign ad_out       = rd_word;
  assign ctl_oe       = claimed || (state_q == ST_TURNOFF);
  assign devsel_n_out = ~claimed;
  assign trdy_n_out   = ~(state_q == ST_DATA);
  assign stop_n_out   = 1'b1;
  assign loc_frame_n  = ~(state_q == ST_CLAIM);
  assign loc_cmd      = cmd_q;
  assign loc_addr     = addr_q;
  assign loc_hit      = ctl_oe ? hit_q : '0;
  assign loc_busy     = ctl_oe;
  assign loc_ack_n    = ~ack_on;
  assign loc_xfr_n    = ~xfr;

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(loc_hit)); // R4
  AST_CLAIM_WITH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !devsel_n_out |-> loc_hit != '0); // R11
  AST_DRIVE_AFTER_TA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> !devsel_n_out && $past(!ctl_oe)); // R3
  AST_TRDY_AFTER_XFR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n_out) |-> $past(loc_xfr_n) == 1'b0); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trdy_n_out) |=> !ctl_oe); // R10
  AST_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_n_out); // R12

endmodule

// File: tb/sim_pci_rd_target.sv
module sim_pci_rd_target;

  localparam int CLK_P = 10;
  localparam int NBAR  = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n, irdy_n;
  logic [3:0]  cbe_n;
  logic [31:0] ad_in, ad_out;
  logic        ad_oe, par_out, par_oe, devsel_n_out, trdy_n_out, stop_n_out, ctl_oe;
  logic [NBAR*32-1:0] bar_base, bar_mask;
  logic [NBAR-1:0]    bar_en;
  logic        loc_frame_n, loc_busy, loc_rdy_n, loc_ack_n, loc_xfr_n;
  logic [3:0]  loc_cmd;
  logic [31:0] loc_addr, loc_data;
  logic [NBAR-1:0] loc_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pci_rd_target #(.NBAR(NBAR), .AW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe),
    .devsel_n_out(devsel_n_out), .trdy_n_out(trdy_n_out), .stop_n_out(stop_n_out),
    .ctl_oe(ctl_oe), .bar_base(bar_base), .bar_mask(bar_mask), .bar_en(bar_en),
    .loc_frame_n(loc_frame_n), .loc_cmd(loc_cmd), .loc_addr(loc_addr), .loc_hit(loc_hit),
    .loc_busy(loc_busy), .loc_rdy_n(loc_rdy_n), .loc_ack_n(loc_ack_n),
    .loc_xfr_n(loc_xfr_n), .loc_data(loc_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] win_base(input int k);
    return 32'h1000_0000 + 32'(k) * 32'h0100_0000;
  endfunction

  task automatic set_default_windows();
    for (int k = 0; k < NBAR; k++) begin
      bar_base[k*32 +: 32] = win_base(k);
      bar_mask[k*32 +: 32] = 32'hFFFF_F000;
    end
    bar_en = '1;
  endtask

  // exp_idx < 0: expect a miss. d: cycles after the address phase that ready is raised, minus one.
  task automatic run_read(input logic [31:0] addr, input logic [3:0] cmd, input int exp_idx,
                          input int d, input logic [3:0] be);
    logic [31:0] word;
    word = addr ^ 32'h5A5A_0F0F ^ 32'(d);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; ad_in = '0; cbe_n = be;
    chk("R3", "turnaround ad_oe", 32'(ad_oe), 32'd0);
    chk("R3", "turnaround ctl_oe", 32'(ctl_oe), 32'd0);
    if (exp_idx >= 0 && d == 0) begin
      loc_rdy_n = 1'b0; loc_data = word;
    end
    @(negedge clk);
    if (exp_idx < 0) begin
      chk("R11", "miss ctl_oe", 32'(ctl_oe), 32'd0);
      chk("R11", "miss loc_frame_n", 32'(loc_frame_n), 32'd1);
      chk("R4", "miss loc_busy", 32'(loc_busy), 32'd0);
      chk("R12", "miss stop_n", 32'(stop_n_out), 32'd1);
      irdy_n = 1'b1;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk("R11", "miss stays off", {29'd0, ctl_oe, ad_oe, loc_ack_n}, 32'd1);
      end
      return;
    end
    chk("R3", "claim devsel_n", 32'(devsel_n_out), 32'd0);
    chk("R3", "claim ad_oe/ctl_oe", {30'd0, ad_oe, ctl_oe}, 32'd3);
    chk("R5", "loc_frame_n", 32'(loc_frame_n), 32'd0);
    chk("R5", "loc_cmd", 32'(loc_cmd), 32'(cmd));
    chk("R5", "loc_addr", loc_addr, addr);
    chk("R4", "loc_hit", 32'(loc_hit), 32'd1 << exp_idx);
    chk("R4", "loc_busy", 32'(loc_busy), 32'd1);
    chk("R6", "ack at claim", 32'(loc_ack_n), 32'd0);
    for (int c = 2; c < 2 + d; c++) begin
      chk("R7", "no early xfr", 32'(loc_xfr_n), 32'd1);
      chk("R6", "ack held", 32'(loc_ack_n), 32'd0);
      if (c == 1 + d) begin
        loc_rdy_n = 1'b0; loc_data = word;
      end
      @(negedge clk);
      chk("R5", "frame strobe one cycle", 32'(loc_frame_n), 32'd1);
    end
    chk("R7", "xfr cycle", 32'(loc_xfr_n), 32'd0);
    chk("R6", "ack in xfr", 32'(loc_ack_n), 32'd0);
    @(negedge clk);
    loc_rdy_n = 1'b1; loc_data = 32'hDEAD_BEEF;
    chk("R7", "xfr single", 32'(loc_xfr_n), 32'd1);
    chk("R6", "ack released", 32'(loc_ack_n), 32'd1);
    chk("R8", "trdy_n", 32'(trdy_n_out), 32'd0);
    chk("R8", "ad_out", ad_out, word);
    chk("R8", "ad_oe", 32'(ad_oe), 32'd1);
    @(negedge clk);
    irdy_n = 1'b1;
    chk("R10", "turnoff trdy/devsel", {30'd0, trdy_n_out, devsel_n_out}, 32'd3);
    chk("R10", "turnoff ctl_oe/ad_oe", {30'd0, ctl_oe, ad_oe}, 32'd2);
    chk("R9", "par_out", 32'(par_out), 32'(^{word, be}));
    chk("R9", "par_oe", 32'(par_oe), 32'd1);
    @(negedge clk);
    chk("R10", "released ctl_oe", 32'(ctl_oe), 32'd0);
    chk("R4", "idle busy/hit", {25'd0, loc_busy, loc_hit}, 32'd0);
    chk("R9", "par_oe off", 32'(par_oe), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; cbe_n = '0; ad_in = '0;
    loc_rdy_n = 1'b1; loc_data = '0; bar_base = '0; bar_mask = '0; bar_en = '0;
    set_default_windows();
    repeat (3) @(negedge clk);
    chk("R1", "reset enables", {29'd0, ctl_oe, ad_oe, par_oe}, 32'd0);
    chk("R1", "reset bus lines", {29'd0, devsel_n_out, trdy_n_out, stop_n_out}, 32'd7);
    chk("R1", "reset local", {25'd0, loc_busy, loc_hit}, 32'd0);
    chk("R1", "reset strobes", {29'd0, loc_frame_n, loc_ack_n, loc_xfr_n}, 32'd7);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // every window, ready delays 0..3
    for (int k = 0; k < NBAR; k++)
      for (int d = 0; d < 4; d++)
        run_read(win_base(k) + 32'(16 * k + 4 * d), 4'b0110, k, d, 4'(k + 3 * d));

    // R2 misses: unmapped address, write command, disabled window
    run_read(32'h2000_0040, 4'b0110, -1, 0, 4'h0);
    run_read(win_base(1) + 32'h10, 4'b0111, -1, 0, 4'h0);
    run_read(win_base(2) + 32'h1000, 4'b0110, -1, 0, 4'h0);
    bar_en = 6'b110111;
    run_read(win_base(3) + 32'h20, 4'b0110, -1, 0, 4'h0);
    bar_en = '1;
    run_read(win_base(3) + 32'h20, 4'b0110, 3, 1, 4'h5);

    // R2 priority: window 4 overlaps window 2, lowest index wins
    bar_base[4*32 +: 32] = win_base(2);
    run_read(win_base(2) + 32'h80, 4'b0110, 2, 2, 4'hA);
    bar_en = 6'b111011;
    run_read(win_base(2) + 32'h80, 4'b0110, 4, 0, 4'hF);
    set_default_windows();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule